// File: doc/BRIEF.md
# Dual Overlapping Serial Pattern Detector

The block watches a serial bit stream, one bit per rising clock edge, and flags two five-bit patterns as they complete. `hit_a` flags the pattern 0,1,1,0,1 and `hit_b` flags the pattern 0,1,1,1,1, both written oldest bit first. Both patterns start with 0,1,1, so one six-state machine follows both of them. Each state stands for the longest tail of the input history that is still the start of either pattern.

The outputs are Mealy outputs. Each one is decoded from the present state and the bit on `bit_in` in the same cycle, so a flag is high during the cycle in which the final bit of its pattern is present. Matches may overlap with an earlier match of the same pattern or of the other pattern. A synchronous reset clears all history.

Top module: `seq_pair_detect`

## Requirements
- R1: `hit_a` is high in a cycle exactly when `bit_in` in that cycle, together with the four bits accepted after reset before it, reads 0,1,1,0,1 (oldest first).
- R2: `hit_b` is high in a cycle exactly when `bit_in` in that cycle, together with the four bits accepted after reset before it, reads 0,1,1,1,1 (oldest first).
- R3: The outputs depend combinationally on `bit_in`. After 0,1,1,0 has been accepted, `hit_a` follows the level of `bit_in` within the same cycle, with no clock edge between them.
- R4: Overlap within one pattern is detected. The stream 0,1,1,0,1,1,0,1 raises `hit_a` on the 5th and the 8th bits.
- R5: Overlap across the two patterns is detected. The stream 0,1,1,0,1,1,1,1 raises `hit_a` on the 5th bit and `hit_b` on the 8th bit.
- R6: `hit_a` and `hit_b` are never high together, and neither is high in two consecutive cycles.
- R7: While `rst` is high both outputs are low. The cycle after `rst` is released starts from an empty history, so a partial prefix seen before reset does not count.
- R8: Streams that contain neither pattern, such as 0,1,1,0,0 or a run of ones, leave both outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one serial bit is accepted per edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit for the current cycle |
| hit_a | output | 1 | Mealy flag: 0,1,1,0,1 completes this cycle |
| hit_b | output | 1 | Mealy flag: 0,1,1,1,1 completes this cycle |

## Verification
A wrong state in this machine cannot be seen at the ports until the input reaches a point where the wrong state and the right state decode differently. In practice this is at most four bits later, when one pattern completes and a flag is either missed or raised with no match. A wrong transition that only shortens the remembered prefix shows up when an overlapping second match goes missing. For that reason the stimulus chains overlapping matches of the same pattern and of the other pattern, and it also runs a long pseudo-random stream against a plain five-bit history model.

// File: rtl/seq_pair_detect_pkg.sv
package seq_pair_detect_pkg;

  localparam int PAT_LEN = 5;
  localparam logic [PAT_LEN-1:0] PAT_A = 5'b01101;
  localparam logic [PAT_LEN-1:0] PAT_B = 5'b01111;
  localparam int ST_W = 3;

  // Each state names the longest history tail that still starts a pattern.
  typedef enum logic [ST_W-1:0] {
    SP_NONE = 3'd0,
    SP_0    = 3'd1,
    SP_01   = 3'd2,
    SP_011  = 3'd3,
    SP_0110 = 3'd4,
    SP_0111 = 3'd5
  } spd_state_e;

  function automatic spd_state_e spd_step(spd_state_e s, logic b);
    spd_state_e n;
    case (s)
      SP_NONE: n = b ? SP_NONE : SP_0;
      SP_0:    n = b ? SP_01   : SP_0;
      SP_01:   n = b ? SP_011  : SP_0;
      SP_011:  n = b ? SP_0111 : SP_0110;
      SP_0110: n = b ? SP_01   : SP_0;    // after 01101 the tail 01 is kept
      SP_0111: n = b ? SP_NONE : SP_0;    // after 01111 no tail is useful
      default: n = SP_NONE;
    endcase
    return n;
  endfunction

  // Bit 1: pattern A completes, bit 0: pattern B completes.
  function automatic logic [1:0] spd_hits(spd_state_e s, logic b);
    logic [1:0] h;
    h = 2'b00;
    if (b && s == SP_0110) h[1] = 1'b1;
    if (b && s == SP_0111) h[0] = 1'b1;
    return h;
  endfunction

endpackage

// File: rtl/spd_next.sv
module spd_next
  import seq_pair_detect_pkg::*;
(
  input  spd_state_e cur_st,
  input  logic       bit_in,
  output spd_state_e nxt_st
);
  always_comb nxt_st = spd_step(cur_st, bit_in);
endmodule

// File: rtl/spd_state.sv
module spd_state
  import seq_pair_detect_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  spd_state_e nxt_st,
  output spd_state_e cur_st
);
  always_ff @(posedge clk) begin
    if (rst) cur_st <= SP_NONE;
    else     cur_st <= nxt_st;
  end
endmodule

// File: rtl/spd_hits.sv
module spd_hits
  import seq_pair_detect_pkg::*;
(
  input  logic       rst,
  input  spd_state_e cur_st,
  input  logic       bit_in,
  output logic       hit_a,
  output logic       hit_b
);
  logic [1:0] raw;
  always_comb begin
    raw   = spd_hits(cur_st, bit_in);
    hit_a = raw[1] & ~rst;
    hit_b = raw[0] & ~rst;
  end
endmodule

// File: rtl/seq_pair_detect.sv
module seq_pair_detect
  import seq_pair_detect_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic hit_a,
  output logic hit_b
);
  spd_state_e st_q;
  spd_state_e st_d;

  spd_next u_next (
    .cur_st (st_q),
    .bit_in (bit_in),
    .nxt_st (st_d)
  );

  spd_state u_state (
    .clk    (clk),
    .rst    (rst),
    .nxt_st (st_d),
    .cur_st (st_q)
  );

  spd_hits u_hits (
    .rst    (rst),
    .cur_st (st_q),
    .bit_in (bit_in),
    .hit_a  (hit_a),
    .hit_b  (hit_b)
  );
endmodule

// File: rtl/seq_pair_detect_chk.sv
module seq_pair_detect_chk
  import seq_pair_detect_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bit_in,
  input logic       hit_a,
  input logic       hit_b,
  input spd_state_e st_q
);
  // Independent history of accepted bits since reset.
  logic [PAT_LEN-2:0] hist;
  logic [2:0]         fill;
  logic               full;
  logic [PAT_LEN-1:0] window;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      fill <= '0;
    end else begin
      hist <= {hist[PAT_LEN-3:0], bit_in};
      if (fill != 3'(PAT_LEN-1)) fill <= fill + 3'd1;
    end
  end

  assign full   = (fill == 3'(PAT_LEN-1));
  assign window = {hist, bit_in};

  a_r1_hit_a_exact: assert property (@(posedge clk) disable iff (rst)
    hit_a == (full && window == PAT_A));

  a_r2_hit_b_exact: assert property (@(posedge clk) disable iff (rst)
    hit_b == (full && window == PAT_B));

  a_r3_mealy_follow: assert property (@(posedge clk) disable iff (rst)
    (st_q == SP_0110) |-> (hit_a == bit_in));

  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(hit_a && hit_b));

  a_r6_pulse_a: assert property (@(posedge clk) disable iff (rst)
    hit_a |=> !hit_a);

  a_r6_pulse_b: assert property (@(posedge clk) disable iff (rst)
    hit_b |=> !hit_b);

  a_r7_quiet_in_reset: assert property (@(posedge clk)
    rst |-> (!hit_a && !hit_b));

  a_r7_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st_q == SP_NONE));
endmodule

bind seq_pair_detect seq_pair_detect_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .bit_in (bit_in),
  .hit_a  (hit_a),
  .hit_b  (hit_b),
  .st_q   (st_q)
);

// File: tb/sim_seq_pair_detect.sv
module sim_seq_pair_detect;
  localparam int CLK_P = 10;
  localparam int NV = 20;
  localparam int NRAND = 3000;

  // {rst, bit_in, expected hit_a, expected hit_b}
  localparam logic [3:0] VEC [NV] = '{
    4'b1000,  // R7 reset, bit 0
    4'b1100,  // R7 reset, bit 1: still quiet
    4'b0000,
    4'b0100,
    4'b0100,
    4'b0000,
    4'b0110,  // R1 01101 completes
    4'b0100,
    4'b0000,
    4'b0110,  // R4 second overlapping 01101
    4'b0100,
    4'b0100,
    4'b0101,  // R2 R5 01111 sharing bits of 01101
    4'b0100,  // R6 no repeat pulse
    4'b0000,
    4'b0100,
    4'b0100,
    4'b0000,
    4'b0000,  // R8 01100 gives nothing
    4'b0100   // R8
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic hit_a, hit_b;
  int   n_chk = 0;
  int   n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  seq_pair_detect u0 (
    .clk    (clk),
    .rst    (rst),
    .bit_in (bit_in),
    .hit_a  (hit_a),
    .hit_b  (hit_b)
  );

  task automatic check(input string tag, input logic ea, input logic eb);
    n_chk++;
    if (hit_a !== ea || hit_b !== eb) begin
      n_bad++;
      $display("FAIL %s: hit_a/hit_b actual %b%b expected %b%b", tag, hit_a, hit_b, ea, eb);
    end
  endtask

  task automatic apply(input logic r, input logic b);
    @(negedge clk);
    rst = r;
    bit_in = b;
    #1;
  endtask

  // Reference: plain history of bits accepted since reset.
  logic [3:0] mh = '0;
  int         mfill = 0;

  task automatic model_eval(input logic r, input logic b, output logic ea, output logic eb);
    ea = !r && mfill >= 4 && {mh, b} == 5'b01101;
    eb = !r && mfill >= 4 && {mh, b} == 5'b01111;
  endtask

  task automatic model_step(input logic r, input logic b);
    if (r) begin
      mh = '0;
      mfill = 0;
    end else begin
      mh = {mh[2:0], b};
      if (mfill < 4) mfill++;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic ea, eb, r, b;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][3], VEC[i][2]);
      check($sformatf("table row %0d", i), VEC[i][1], VEC[i][0]);
    end

    // R3: in the cycle after 0,1,1,0 hit_a tracks bit_in without a clock edge
    apply(1'b1, 1'b0);
    apply(1'b0, 1'b0);
    apply(1'b0, 1'b1);
    apply(1'b0, 1'b1);
    apply(1'b0, 1'b0);
    apply(1'b0, 1'b0);
    check("R3 low bit", 1'b0, 1'b0);
    bit_in = 1'b1;
    #1;
    check("R3 high bit", 1'b1, 1'b0);
    bit_in = 1'b0;
    #1;
    check("R3 back low", 1'b0, 1'b0);

    // R7: reset drops a pending 0110 prefix
    apply(1'b0, 1'b0);
    apply(1'b0, 1'b1);
    apply(1'b0, 1'b1);
    apply(1'b0, 1'b0);
    apply(1'b1, 1'b1);
    check("R7 during reset", 1'b0, 1'b0);
    apply(1'b0, 1'b1);
    check("R7 prefix forgotten", 1'b0, 1'b0);

    // R8: long run of ones
    for (int i = 0; i < 12; i++) begin
      apply(1'b0, 1'b1);
      check("R8 ones run", 1'b0, 1'b0);
    end

    // R1 R2 R4 R5 R6 R7: pseudo-random stream against the history model
    apply(1'b1, 1'b0);
    model_step(1'b1, 1'b0);
    lfsr = 16'hACE1;
    for (int i = 0; i < NRAND; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = (lfsr[15:9] == 7'd0);
      b = lfsr[3];
      apply(r, b);
      model_eval(r, b, ea, eb);
      check($sformatf("R1 R2 random step %0d", i), ea, eb);
      model_step(r, b);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule